// File: doc/BRIEF.md
# Audio Sample Receive FIFO

This block sits between a converter's sample output and a processor bus. Each cycle the converter side may offer one 32-bit sample word with a valid strobe, and the block stores it in a 32-entry first-in first-out buffer. The bus side sees a read-only data port. That port always shows the word a read would return. A read strobe at a clock edge removes that word.

Software watches the buffer through a full bit, an empty bit, a 5-bit occupancy field and a threshold flag. It can also enable a threshold interrupt. The read port reshapes each word to one of four widths at read time. A read against an empty buffer returns the previously read word again. Dropping the converter enable flushes the buffer.

Top module: `audio_rx_fifo`

## Requirements
- R1: The buffer holds 32 words. `stat_level` shows the held count modulo 32, and `stat_full` is 1 exactly when 32 words are held, so a full buffer shows `stat_full`=1 with `stat_level`=0.
- R2: `rd_word` shows the oldest held word while the buffer is not empty. A clock edge with `rd_pop`=1 removes it, and words leave in the order they were written.
- R3: A clock edge with `rd_pop`=1 while empty moves nothing. `rd_word` then shows the most recently removed word again, or zero if nothing has been removed since reset.
- R4: A clock edge with `conv_en`=0 empties the buffer. Write strobes are ignored while `conv_en` is 0.
- R5: `width_sel` sets the read width. 0 gives the whole 32-bit word. 1 gives bits 31:16, 2 gives bits 31:24 and 3 gives bits 31:8. Each narrower value is sign-extended to 32 bits. The selection applies to the word at read time.
- R6: `stat_thresh` is 1 when the held count (0 to 32) is greater than or equal to the 4-bit `thresh_lvl`.
- R7: `thresh_irq` is 1 only when `stat_thresh` and `thresh_ie` are both 1.
- R8: `stat_empty` is 1 exactly when no words are held.
- R9: A write offered while the buffer is full is dropped. The 32 stored words and their order are unchanged.
- R10: A write and a read at the same edge, with the buffer neither empty nor full, leave the count unchanged. The read still removes the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_en | input | 1 | Converter enable; low flushes the buffer |
| wr_valid | input | 1 | Sample write strobe |
| wr_word | input | 32 | Sample word |
| rd_pop | input | 1 | Read strobe; removes one word at the edge |
| width_sel | input | 2 | Read width select (0:32, 1:16, 2:8, 3:24) |
| thresh_lvl | input | 4 | Threshold level |
| thresh_ie | input | 1 | Threshold interrupt enable |
| rd_word | output | 32 | Read data port |
| stat_full | output | 1 | Buffer holds 32 words |
| stat_empty | output | 1 | Buffer holds no words |
| stat_level | output | 5 | Held count modulo 32 |
| stat_thresh | output | 1 | Count at or above threshold |
| thresh_irq | output | 1 | Gated threshold interrupt |

## Verification
A short burst of distinct words, read back in order, separates correct ordering from swapped or stale pointers. A fill to 32 words followed by one extra write shows whether the wrap, the full encoding and the dropping of the overflow word are correct. Negative and positive samples read under each width select show whether sign extension and field placement are correct. A count stepped across the threshold, with the enable toggled, tests the comparison edge and the interrupt gate. Reads against an empty buffer, same-edge read-write traffic and an enable drop test the repeat-last rule, the count bookkeeping and the flush.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  localparam int SAMPLE_W = 32;
  localparam int HALF_W   = SAMPLE_W / 2;
  localparam int QTR_W    = SAMPLE_W / 4;
  localparam int TRI_W    = (3 * SAMPLE_W) / 4;

  typedef enum logic [1:0] {
    FMT_FULL  = 2'd0,
    FMT_HALF  = 2'd1,
    FMT_QTR   = 2'd2,
    FMT_TRI   = 2'd3
  } fmt_e;

  // Take the top bits of a sample and sign-extend them to the full width.
  function automatic logic [SAMPLE_W-1:0] shape_word(input logic [SAMPLE_W-1:0] raw,
                                                     input fmt_e f);
    logic [SAMPLE_W-1:0] r;
    case (f)
      FMT_HALF: r = {{(SAMPLE_W-HALF_W){raw[SAMPLE_W-1]}}, raw[SAMPLE_W-1 -: HALF_W]};
      FMT_QTR:  r = {{(SAMPLE_W-QTR_W){raw[SAMPLE_W-1]}},  raw[SAMPLE_W-1 -: QTR_W]};
      FMT_TRI:  r = {{(SAMPLE_W-TRI_W){raw[SAMPLE_W-1]}},  raw[SAMPLE_W-1 -: TRI_W]};
      default:  r = raw;
    endcase
    return r;
  endfunction

  // Occupancy versus threshold; both widened before the compare.
  function automatic logic at_or_above(input logic [7:0] count, input logic [7:0] lvl);
    return count >= lvl;
  endfunction
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int DEPTH = 32,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          push_req,
  input  logic          pop_req,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] count,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          is_full,
  output logic          is_empty
);
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  assign is_full  = (count == CAP);
  assign is_empty = (count == '0);
  assign push_ok  = enable && push_req && !is_full;
  assign pop_ok   = pop_req && !is_empty;

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/afifo_hold.sv
module afifo_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic          use_held,
  input  logic [DW-1:0] head,
  output logic [DW-1:0] sel_word
);
  logic [DW-1:0] held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       held_q <= '0;
    else if (capture) held_q <= head;
  end

  assign sel_word = use_held ? held_q : head;
endmodule

// File: rtl/audio_rx_fifo.sv
module audio_rx_fifo
  import afifo_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int TH_W   = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                conv_en,
  input  logic                wr_valid,
  input  logic [SAMPLE_W-1:0] wr_word,
  input  logic                rd_pop,
  input  logic [1:0]          width_sel,
  input  logic [TH_W-1:0]     thresh_lvl,
  input  logic                thresh_ie,
  output logic [SAMPLE_W-1:0] rd_word,
  output logic                stat_full,
  output logic                stat_empty,
  output logic [AW-1:0]       stat_level,
  output logic                stat_thresh,
  output logic                thresh_irq
);
  logic [AW-1:0]       wptr, rptr;
  logic [CW-1:0]       count;
  logic                push_ok, pop_ok, is_full, is_empty;
  logic [SAMPLE_W-1:0] head_word, chosen_raw;
  logic                empty_pop;

  afifo_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .enable(conv_en),
    .push_req(wr_valid), .pop_req(rd_pop),
    .wptr(wptr), .rptr(rptr), .count(count),
    .push_ok(push_ok), .pop_ok(pop_ok),
    .is_full(is_full), .is_empty(is_empty)
  );

  afifo_store #(.DEPTH(DEPTH), .DW(SAMPLE_W)) store_i (
    .clk(clk), .we(push_ok), .waddr(wptr), .wdata(wr_word),
    .raddr(rptr), .rdata(head_word)
  );

  afifo_hold #(.DW(SAMPLE_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .capture(pop_ok), .use_held(is_empty),
    .head(head_word), .sel_word(chosen_raw)
  );

  assign empty_pop   = rd_pop && is_empty;
  assign rd_word     = shape_word(chosen_raw, fmt_e'(width_sel));
  assign stat_full   = is_full;
  assign stat_empty  = is_empty;
  assign stat_level  = count[AW-1:0];
  assign stat_thresh = at_or_above(8'(count), 8'(thresh_lvl));
  assign thresh_irq  = stat_thresh && thresh_ie;
endmodule

// File: rtl/afifo_checks.sv
module afifo_checks #(
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_en,
  input logic          wr_valid,
  input logic          rd_pop,
  input logic [1:0]    width_sel,
  input logic [3:0]    thresh_lvl,
  input logic          thresh_ie,
  input logic [31:0]   rd_word,
  input logic          stat_full,
  input logic          stat_empty,
  input logic [AW-1:0] stat_level,
  input logic          stat_thresh,
  input logic          thresh_irq,
  input logic          empty_pop
);
  logic [AW:0] occ;
  assign occ = {stat_full, stat_level};

  a_r1_full_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    stat_full |-> (stat_level == '0) && !stat_empty);

  a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_empty |-> (occ == '0));

  a_r3_repeat_last: assert property (@(posedge clk) disable iff (!rst_n)
    empty_pop && !(conv_en && wr_valid) |=>
      stat_empty && ((width_sel != $past(width_sel)) || (rd_word == $past(rd_word))));

  a_r4_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> stat_empty);

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en && stat_full && wr_valid && !rd_pop |=> stat_full);

  a_r10_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en && wr_valid && rd_pop && !stat_empty && !stat_full |=> $stable(occ));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_irq |-> thresh_ie && (occ >= {2'b00, thresh_lvl}));
endmodule

bind audio_rx_fifo afifo_checks #(.AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .wr_valid(wr_valid),
  .rd_pop(rd_pop), .width_sel(width_sel), .thresh_lvl(thresh_lvl),
  .thresh_ie(thresh_ie), .rd_word(rd_word), .stat_full(stat_full),
  .stat_empty(stat_empty), .stat_level(stat_level),
  .stat_thresh(stat_thresh), .thresh_irq(thresh_irq), .empty_pop(empty_pop)
);

// File: tb/audio_rx_fifo_tb.sv
`timescale 1ns/1ps
module audio_rx_fifo_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        rd_pop = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic [3:0]  thresh_lvl = 4'd0;
  logic        thresh_ie = 1'b0;
  logic [31:0] rd_word;
  logic        stat_full, stat_empty, stat_thresh, thresh_irq;
  logic [4:0]  stat_level;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] sb_q[$];
  logic [31:0] sb_last = '0;

  always #2.5 clk = ~clk;

  audio_rx_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .wr_valid(wr_valid),
    .wr_word(wr_word), .rd_pop(rd_pop), .width_sel(width_sel),
    .thresh_lvl(thresh_lvl), .thresh_ie(thresh_ie), .rd_word(rd_word),
    .stat_full(stat_full), .stat_empty(stat_empty), .stat_level(stat_level),
    .stat_thresh(stat_thresh), .thresh_irq(thresh_irq)
  );

  function automatic logic [31:0] expect_fmt(input logic [31:0] x, input logic [1:0] w);
    logic signed [31:0] s;
    s = x;
    case (w)
      2'd1: return s >>> 16;
      2'd2: return s >>> 24;
      2'd3: return s >>> 8;
      default: return x;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_occ(input string tag, input int n);
    chk({tag, " count"}, 32'({stat_full, stat_level}), 32'(n));
    chk({tag, " empty"}, 32'(stat_empty), 32'(n == 0));
  endtask

  // Driver: offers one word; the scoreboard keeps it if the buffer has room.
  task automatic put(input logic [31:0] w);
    @(negedge clk);
    wr_valid = 1'b1; wr_word = w;
    if (conv_en && sb_q.size() < 32) sb_q.push_back(w);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  // Monitor side: compares the port against the scoreboard head, then pops.
  task automatic get(input string tag);
    logic [31:0] exp;
    @(negedge clk);
    exp = (sb_q.size() != 0) ? sb_q[0] : sb_last;
    chk(tag, rd_word, expect_fmt(exp, width_sel));
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    if (sb_q.size() != 0) sb_last = sb_q.pop_front();
  endtask

  task automatic put_get(input logic [31:0] w, input string tag);
    @(negedge clk);
    chk(tag, rd_word, expect_fmt(sb_q[0], width_sel));
    wr_valid = 1'b1; wr_word = w; rd_pop = 1'b1;
    sb_last = sb_q.pop_front();
    sb_q.push_back(w);
    @(negedge clk);
    wr_valid = 1'b0; rd_pop = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<60000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; conv_en = 1'b1;
    @(negedge clk);
    chk_occ("R8 reset", 0);
    chk("R7 reset irq", 32'(thresh_irq), 32'd0);
    chk("R3 reset data", rd_word, 32'd0);

    // R2: order
    put(32'h1111_0001); put(32'h2222_0002); put(32'h3333_0003);
    @(negedge clk); chk_occ("R1 three", 3);
    get("R2 first"); get("R2 second"); get("R2 third");
    // R3: repeat past empty
    get("R3 repeat a"); get("R3 repeat b");
    @(negedge clk); chk_occ("R3 still empty", 0);

    // R1 / R9: fill to 32 then one extra
    for (int i = 0; i < 32; i++) put(32'hA000_0000 + 32'(i));
    @(negedge clk); chk_occ("R1 full", 32);
    chk("R1 full bit", 32'(stat_full), 32'd1);
    put(32'hDEAD_BEEF);
    @(negedge clk); chk_occ("R9 still full", 32);
    thresh_lvl = 4'd15;
    @(negedge clk); chk("R6 full above", 32'(stat_thresh), 32'd1);
    for (int i = 0; i < 32; i++) get("R9 drain");
    @(negedge clk); chk_occ("R9 drained", 0);
    get("R9 repeat last");

    // R6 / R7: threshold
    thresh_lvl = 4'd0;
    @(negedge clk); chk("R6 zero level", 32'(stat_thresh), 32'd1);
    thresh_lvl = 4'd5; thresh_ie = 1'b0;
    for (int i = 0; i < 4; i++) put(32'h0000_0100 + 32'(i));
    @(negedge clk);
    chk("R6 below", 32'(stat_thresh), 32'd0);
    thresh_ie = 1'b1;
    @(negedge clk); chk("R7 below gated", 32'(thresh_irq), 32'd0);
    thresh_ie = 1'b0;
    put(32'h0000_0200);
    @(negedge clk);
    chk("R6 equal", 32'(stat_thresh), 32'd1);
    chk("R7 disabled", 32'(thresh_irq), 32'd0);
    thresh_ie = 1'b1;
    @(negedge clk); chk("R7 enabled", 32'(thresh_irq), 32'd1);
    thresh_ie = 1'b0;

    // R10: simultaneous traffic at level 5
    put_get(32'h5555_0001, "R10 head a");
    put_get(32'h5555_0002, "R10 head b");
    @(negedge clk); chk_occ("R10 level", 5);

    // R4: flush and ignore writes while disabled
    @(negedge clk); conv_en = 1'b0;
    sb_q.delete();
    @(negedge clk); chk_occ("R4 flushed", 0);
    put(32'h7777_7777);
    @(negedge clk); chk_occ("R4 write ignored", 0);
    conv_en = 1'b1;
    get("R4 repeat after flush");

    // R5: widths
    put(32'h8123_4567); put(32'h7ABC_DEF0); put(32'h8000_0001);
    width_sel = 2'd1; get("R5 half");
    width_sel = 2'd2; get("R5 quarter");
    width_sel = 2'd3; get("R5 three-quarter");
    get("R5 repeat reformat");
    width_sel = 2'd2; get("R5 repeat narrow");
    width_sel = 2'd0; get("R5 full width");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule